// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block turns the timing strobes of a timekeeping counter into one selectable periodic interrupt. A 3-bit cycle code picks one of four behaviours. The interrupt can be held inactive. It can be forced active. It can run as a free-running 50% square wave at one of two rates. It can also act as a latched level interrupt that fires on a second, minute, hour or month boundary and then waits for the host. The interrupt is active low, in the style of an open-drain output. A 2-bit routing field sends it to either of two output pins, to both, or to neither.

The host side is a simple register strobe interface. One write loads the cycle code and the routing field together. A second write port acts on the status flag. The flag always reads 1 while the interrupt is active, so the host can poll it. In a level mode, writing 0 to the flag releases the output. In the pulse modes, flag writes are ignored.

The falling edge in a level mode trails the seconds strobe by a fixed number of slow-clock cycles. This models the short lag between the seconds count-up and the pin going low.

Top module: `pi_periodic_irq`

## Requirements
- R1: After reset the cycle code is 000 and the routing field is 01. Both pins read 1 and the flag reads 0.
- R2: Cycle code 000 holds the interrupt inactive (high). Cycle code 001 holds it active (low) for as long as the code stays selected.
- R3: Code 010 is a square wave that toggles on every `tick_q` strobe. Code 011 toggles on every second `tick_q` strobe. After a cycle write the wave starts high. With code 010 the first strobe drives it low. With code 011 the pattern over the strobes is high, low, low, high.
- R4: In codes 100 to 111, the interrupt goes low at the third rising clock edge after the edge that samples a qualifying seconds strobe. It is still high at the second such edge.
- R5: A qualifying event requires `sec_stb`. Code 100 qualifies on every `sec_stb`. Codes 101, 110 and 111 additionally need `min_roll`, `hour_roll` or `month_roll`, respectively, in the same cycle. A rollover strobe without `sec_stb`, or with the wrong rollover strobe, has no effect.
- R6: In codes 100 to 111 the interrupt stays low until a flag write with data 0. That write releases it at the edge that samples the write. A flag write with data 1 has no effect. The next qualifying event asserts the interrupt again. If a set and a release land on the same edge, the set wins.
- R7: In codes 000 to 011, a flag write with either data value leaves the pins and the flag unchanged.
- R8: A cycle write cancels any event still in the delay line and any latched level. It also restarts the square-wave phase, so the interrupt is high right after the write unless the new code is 001.
- R9: Routing bit 0 connects the interrupt to `pin_a_n` and bit 1 connects it to `pin_b_n`. A pin that is not connected reads 1.
- R10: `flag_o` reads 1 exactly while the internal interrupt is active, whatever the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_q | input | 1 | One-cycle strobe at four times per second |
| sec_stb | input | 1 | One-cycle seconds count-up strobe |
| min_roll | input | 1 | Minute boundary, valid with `sec_stb` |
| hour_roll | input | 1 | Hour boundary, valid with `sec_stb` |
| month_roll | input | 1 | Month boundary, valid with `sec_stb` |
| cfg_we | input | 1 | Write strobe for cycle code and routing |
| cfg_cycle | input | 3 | Cycle code written on `cfg_we` |
| cfg_route | input | 2 | Routing field written on `cfg_we` |
| flag_we | input | 1 | Write strobe for the status flag |
| flag_wdata | input | 1 | Flag write data, 0 releases a level interrupt |
| flag_o | output | 1 | Status flag, 1 while the interrupt is active |
| pin_a_n | output | 1 | Interrupt pin A, active low |
| pin_b_n | output | 1 | Interrupt pin B, active low |

## Verification
The bench probes the exact edge of the level-mode fall. It checks that the pin is high two edges after the seconds strobe and low at the third. An off-by-one delay line would fail one of those two samples. It feeds each level code the wrong rollover strobe, and a rollover strobe without the seconds strobe. A decoder that ignores the seconds qualifier or mixes up the boundaries would assert there. It also rewrites the cycle code while an event is still in flight and while the latch is set. A design that kept stale state would fall a few cycles later or stay low. Finally, it issues flag writes in the pulse modes and a flag write of 1 in a level mode. A design with a loose clear decode would release the output or disturb the wave.

// File: rtl/pi_pkg.sv
// Shared types for the periodic interrupt generator.
// Assumes the cycle code is the 3-bit field written by the host.
package pi_pkg;

    typedef enum logic [2:0] {
        CYC_OFF   = 3'b000,
        CYC_LOW   = 3'b001,
        CYC_FAST  = 3'b010,
        CYC_SLOW  = 3'b011,
        CYC_SEC   = 3'b100,
        CYC_MIN   = 3'b101,
        CYC_HOUR  = 3'b110,
        CYC_MONTH = 3'b111
    } cyc_e;

    // Level modes are the codes with the top bit set.
    function automatic logic is_level(input cyc_e c);
        return c[2];
    endfunction

endpackage

// File: rtl/pi_evt_delay.sv
// Fixed-length delay line for qualified seconds events.
// Assumes each event is a one-cycle strobe. A flush empties every stage.
module pi_evt_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic evt_in,
    output logic evt_out
);

    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            // Purpose: one-stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) stage_q <= '0;
                else                 stage_q <= evt_in;
            end
        end else begin : g_chain
            // Purpose: shift the event one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) stage_q <= '0;
                else                 stage_q <= {stage_q[DEPTH-2:0], evt_in};
            end
        end
    endgenerate

    assign evt_out = stage_q[DEPTH-1];

    // R8: a flush leaves no event in flight.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stage_q == '0));

endmodule

// File: rtl/pi_pulse_gen.sv
// Phase counter behind the square-wave modes.
// Bit 0 toggles on every tick and bit 1 on every second tick.
// Assumes restart has priority over tick.
module pi_pulse_gen #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tick,
    output logic [PHASE_W-1:0] phase
);

    // Purpose: advance the phase on each tick, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (tick)         phase <= phase + 1'b1;
    end

    // R3: without a tick the phase holds.
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(phase));

endmodule

// File: rtl/pi_level_latch.sv
// Latched level interrupt for the boundary-aligned modes.
// Assumes set is the delayed qualified event and clr is the decoded host release.
module pi_level_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic active
);

    // Purpose: hold the level until released; set wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) active <= 1'b0;
        else if (set)        active <= 1'b1;
        else if (clr)        active <= 1'b0;
    end

    // R6: an asserted level holds without a release.
    a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr && !flush) |=> active);

    // R6: a release without a coincident set drops the level.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set && !flush) |=> !active);

endmodule

// File: rtl/pi_pin_route.sv
// Steers the active-low interrupt onto any subset of the output pins.
// Assumes an unrouted pin must read inactive (high).
module pi_pin_route #(
    parameter int NUM_PINS = 2
) (
    input  logic                irq_n,
    input  logic [NUM_PINS-1:0] route,
    output logic [NUM_PINS-1:0] pins_n
);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            // Purpose: pass the interrupt to pin i only when routed.
            assign pins_n[i] = route[i] ? irq_n : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pi_periodic_irq.sv
// Periodic interrupt generator, top level.
// Holds the cycle and routing registers and decodes the qualifying events.
// Selects the interrupt source by cycle code and drives the status flag.
// Assumes the rollover strobes are valid only alongside sec_stb.
module pi_periodic_irq #(
    parameter int EDGE_DLY = 3,
    parameter int PHASE_W  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_q,
    input  logic       sec_stb,
    input  logic       min_roll,
    input  logic       hour_roll,
    input  logic       month_roll,
    input  logic       cfg_we,
    input  logic [2:0] cfg_cycle,
    input  logic [1:0] cfg_route,
    input  logic       flag_we,
    input  logic       flag_wdata,
    output logic       flag_o,
    output logic       pin_a_n,
    output logic       pin_b_n
);
    import pi_pkg::*;

    localparam int           NUM_PINS    = 2;
    localparam logic [1:0]   ROUTE_RESET = 2'b01;

    cyc_e                cyc_q;
    logic [NUM_PINS-1:0] route_q;
    logic                evt_qual;
    logic                evt_late;
    logic                lvl_clr;
    logic                lvl_active;
    logic [PHASE_W-1:0]  phase;
    logic                irq_n;
    logic [NUM_PINS-1:0] pins_n;

    // Purpose: host-written cycle code and routing field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= CYC_OFF;
            route_q <= ROUTE_RESET;
        end else if (cfg_we) begin
            cyc_q   <= cyc_e'(cfg_cycle);
            route_q <= cfg_route;
        end
    end

    // Purpose: decide whether this cycle's strobes form a qualifying event.
    always_comb begin
        unique case (cyc_q)
            CYC_SEC:   evt_qual = sec_stb;
            CYC_MIN:   evt_qual = sec_stb && min_roll;
            CYC_HOUR:  evt_qual = sec_stb && hour_roll;
            CYC_MONTH: evt_qual = sec_stb && month_roll;
            default:   evt_qual = 1'b0;
        endcase
    end

    // Purpose: a flag write of 0 releases the level only in level modes.
    assign lvl_clr = flag_we && !flag_wdata && is_level(cyc_q);

    pi_evt_delay #(.DEPTH(EDGE_DLY)) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cfg_we),
        .evt_in  (evt_qual),
        .evt_out (evt_late)
    );

    pi_level_latch i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (cfg_we),
        .set    (evt_late),
        .clr    (lvl_clr),
        .active (lvl_active)
    );

    pi_pulse_gen #(.PHASE_W(PHASE_W)) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .tick    (tick_q),
        .phase   (phase)
    );

    // Purpose: pick the interrupt source for the selected cycle code.
    always_comb begin
        unique case (cyc_q)
            CYC_OFF:  irq_n = 1'b1;
            CYC_LOW:  irq_n = 1'b0;
            CYC_FAST: irq_n = !phase[0];
            CYC_SLOW: irq_n = !phase[1];
            default:  irq_n = !lvl_active;
        endcase
    end

    pi_pin_route #(.NUM_PINS(NUM_PINS)) i_route (
        .irq_n  (irq_n),
        .route  (route_q),
        .pins_n (pins_n)
    );

    assign pin_a_n = pins_n[0];
    assign pin_b_n = pins_n[1];
    assign flag_o  = !irq_n;

    // R1: the first cycle out of reset is idle on both pins.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pin_a_n && pin_b_n && !flag_o));

    // R2: the forced-low code reaches a routed pin.
    a_r2_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_LOW && route_q[0]) |-> !pin_a_n);

    // R7: a pulse-mode flag write without a tick leaves the output alone.
    a_r7_flag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level(cyc_q) && flag_we && !tick_q && !cfg_we) |=> $stable(irq_n));

    // R8: right after a cycle write only the forced-low code is active.
    a_r8_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (irq_n || cyc_q == CYC_LOW));

    // R9: an unrouted pin stays high.
    a_r9_unrouted_high: assert property (@(posedge clk) disable iff (!rst_n)
        !route_q[1] |-> pin_b_n);

endmodule

// File: tb/test_pi_periodic_irq.sv
module test_pi_periodic_irq;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 6;
    // Vector: {cycle[2:0], route[1:0], exp_pin_a, exp_pin_b, exp_flag}
    localparam logic [7:0] VEC [NVEC] = '{
        {3'b000, 2'b01, 1'b1, 1'b1, 1'b0},
        {3'b001, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'b001, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'b001, 2'b11, 1'b0, 1'b0, 1'b1},
        {3'b001, 2'b00, 1'b1, 1'b1, 1'b1},
        {3'b000, 2'b11, 1'b1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_q = 1'b0, sec_stb = 1'b0, min_roll = 1'b0, hour_roll = 1'b0, month_roll = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_cycle = '0;
    logic [1:0] cfg_route = '0;
    logic       flag_we = 1'b0, flag_wdata = 1'b0;
    logic       flag_o, pin_a_n, pin_b_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pi_periodic_irq i_pi_periodic_irq (
        .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .sec_stb(sec_stb),
        .min_roll(min_roll), .hour_roll(hour_roll), .month_roll(month_roll),
        .cfg_we(cfg_we), .cfg_cycle(cfg_cycle), .cfg_route(cfg_route),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .flag_o(flag_o), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] c, input logic [1:0] r);
        @(negedge clk); cfg_we = 1'b1; cfg_cycle = c; cfg_route = r;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic flag_write(input logic d);
        @(negedge clk); flag_we = 1'b1; flag_wdata = d;
        @(negedge clk); flag_we = 1'b0;
    endtask

    task automatic strobe(input logic t, input logic s, input logic m, input logic h, input logic mo);
        @(negedge clk);
        tick_q = t; sec_stb = s; min_roll = m; hour_roll = h; month_roll = mo;
        @(negedge clk);
        tick_q = 0; sec_stb = 0; min_roll = 0; hour_roll = 0; month_roll = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pin_a after reset", pin_a_n, 1'b1);
        chk("R1", "pin_b after reset", pin_b_n, 1'b1);
        chk("R1", "flag after reset", flag_o, 1'b0);

        // Table walk: static codes 000/001 across routings (R2, R9, R10).
        for (int i = 0; i < NVEC; i++) begin
            cfg(VEC[i][7:5], VEC[i][4:3]);
            idle(2);
            chk("R2/R9", "pin_a vector", pin_a_n, VEC[i][2]);
            chk("R2/R9", "pin_b vector", pin_b_n, VEC[i][1]);
            chk("R10", "flag vector", flag_o, VEC[i][0]);
        end

        // R3: fast square wave.
        cfg(3'b010, 2'b01);
        chk("R3", "fast start high", pin_a_n, 1'b1);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "fast after tick1", pin_a_n, 1'b0);
        // R7: flag writes in pulse mode change nothing.
        flag_write(1'b0);
        chk("R7", "pulse pin after flag write 0", pin_a_n, 1'b0);
        chk("R7", "pulse flag after flag write 0", flag_o, 1'b1);
        flag_write(1'b1);
        chk("R7", "pulse pin after flag write 1", pin_a_n, 1'b0);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "fast after tick2", pin_a_n, 1'b1);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "fast after tick3", pin_a_n, 1'b0);
        // R8: rewrite restarts the phase.
        cfg(3'b010, 2'b01);
        chk("R8", "fast restart high", pin_a_n, 1'b1);

        // R3: slow square wave, pattern high, low, low, high.
        cfg(3'b011, 2'b01);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "slow after tick1", pin_a_n, 1'b1);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "slow after tick2", pin_a_n, 1'b0);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "slow after tick3", pin_a_n, 1'b0);
        strobe(1, 0, 0, 0, 0);
        chk("R3", "slow after tick4", pin_a_n, 1'b1);

        // R4: every-second level mode, exact fall edge.
        cfg(3'b100, 2'b01);
        strobe(0, 1, 0, 0, 0);
        idle(2);
        chk("R4", "level high at edge 2", pin_a_n, 1'b1);
        idle(1);
        chk("R4", "level low at edge 3", pin_a_n, 1'b0);
        chk("R10", "level flag set", flag_o, 1'b1);
        // R6: hold, write 1 ignored, write 0 releases, re-assert.
        idle(4);
        chk("R6", "level holds", pin_a_n, 1'b0);
        flag_write(1'b1);
        chk("R6", "flag write 1 ignored", pin_a_n, 1'b0);
        flag_write(1'b0);
        chk("R6", "flag write 0 releases", pin_a_n, 1'b1);
        chk("R6", "flag cleared", flag_o, 1'b0);
        strobe(0, 1, 0, 0, 0);
        idle(3);
        chk("R6", "next event reasserts", pin_a_n, 1'b0);

        // R5: minute qualification.
        cfg(3'b101, 2'b01);
        strobe(0, 1, 0, 0, 0);
        idle(4);
        chk("R5", "minute mode sec only", pin_a_n, 1'b1);
        strobe(0, 0, 1, 0, 0);
        idle(4);
        chk("R5", "minute mode roll only", pin_a_n, 1'b1);
        strobe(0, 1, 1, 0, 0);
        idle(3);
        chk("R5", "minute mode fires", pin_a_n, 1'b0);

        // R5: hour qualification.
        cfg(3'b110, 2'b01);
        strobe(0, 1, 1, 0, 0);
        idle(4);
        chk("R5", "hour mode wrong roll", pin_a_n, 1'b1);
        strobe(0, 1, 0, 1, 0);
        idle(3);
        chk("R5", "hour mode fires", pin_a_n, 1'b0);

        // R5: month qualification.
        cfg(3'b111, 2'b01);
        strobe(0, 1, 0, 1, 0);
        idle(4);
        chk("R5", "month mode wrong roll", pin_a_n, 1'b1);
        strobe(0, 0, 0, 0, 1);
        idle(4);
        chk("R5", "month mode roll only", pin_a_n, 1'b1);
        strobe(0, 1, 0, 0, 1);
        idle(3);
        chk("R5", "month mode fires", pin_a_n, 1'b0);

        // R8: cycle write cancels an asserted level and an event in flight.
        cfg(3'b100, 2'b01);
        chk("R8", "asserted level cancelled", pin_a_n, 1'b1);
        strobe(0, 1, 0, 0, 0);
        cfg(3'b100, 2'b01);
        idle(5);
        chk("R8", "pending event cancelled", pin_a_n, 1'b1);

        // R9: level interrupt routed to pin B only.
        cfg(3'b100, 2'b10);
        strobe(0, 1, 0, 0, 0);
        idle(3);
        chk("R9", "pin_a unrouted", pin_a_n, 1'b1);
        chk("R9", "pin_b routed", pin_b_n, 1'b0);
        chk("R10", "flag independent of route", flag_o, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule